// File: doc/BRIEF.md
# Buffered Eight-Channel PWM Timer

This block generates eight pulse-width-modulated outputs from one shared up-counter. A period register fixes how far the counter runs before it wraps to zero. Each output rises at the wrap point and falls when the counter reaches that output's duty value. Software never writes the duty values directly. It writes four buffer registers, and their contents are copied into the live duty registers only at a wrap point, so a new duty value never cuts a pulse short. A route bit chooses whether the four buffers feed duty slots 0 to 3 or duty slots 4 to 7.

A prescaler divides the system clock by a power of two before it reaches the counter. A run bit starts and stops the timer, and each output has a polarity bit and an enable bit. A wrap-point flag can raise an interrupt. All registers sit behind a simple single-cycle write port and a combinational read port.

Register map (4-bit word address, 16-bit data): 0 control, 1 period, 2 polarity, 3 output enable, 4 to 7 buffers 0 to 3, 8 to 15 duty slots 0 to 7 (read-only). Control bits: bit 0 run, bit 1 interrupt enable, bit 2 wrap flag, bit 3 route, bits 6:4 prescaler code.

Top module: `pwm_bank_timer`

## Requirements
- R1: A write that takes the run bit (control bit 0) from 0 to 1 causes a wrap event on the next clock edge. That event loads the buffers into the duty slots, sets the flag (control bit 2) and clears the counter, and the outputs become active from then on.
- R2: While running, the counter steps once every 2^code clocks, where code is control bits 6:4 (0 to 7). It wraps to zero on the step that follows the count equal to the period register. One period is therefore (period+1)*2^code clocks, and every wrap sets the flag.
- R3: The duty slots change only at a wrap event. A buffer write between wraps leaves the duty readback (addresses 8 to 15) unchanged.
- R4: With route (control bit 3) at 0, buffers 0 to 3 load duty slots 0 to 3 at a wrap. With route at 1, they load duty slots 4 to 7, and slots 0 to 3 keep their values.
- R5: An active output is high while the counter is below its duty value and low from the count equal to the duty value until the next wrap. A duty value equal to or above the period keeps the output high for the whole period, and a duty value of 0 keeps it low.
- R6: Polarity bit i (address 2) set to 1 inverts output i.
- R7: An output whose enable bit (address 3) is 0 drives its polarity bit's value at all times.
- R8: The flag stays at 1 until a control write with bit 2 equal to 0. A control write with bit 2 equal to 1 does not set it. A wrap in the same cycle as a clearing write leaves it set.
- R9: The interrupt request is high exactly when both the flag and the interrupt-enable bit (control bit 1) are 1.
- R10: While the run bit is 0, the counter is held at zero and every output equals its polarity bit. The duty slots keep their values.
- R11: After reset, all registers read 0, all outputs are low and the interrupt request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| pwm_o | output | 8 | PWM outputs |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is the exact period boundary: showing that a period has exactly (period+1)*2^code clocks and that the flag does not return one cycle early. Each table vector starts the timer, clears the flag one cycle after the start event, and counts output-high clocks across exactly one period. It then checks that the flag is still clear on the last clock of the period and set on the clock after it. Because the duty slots can be seen only through readback, the double-buffering and route tests write a buffer in mid-period and read the duty slots before and after the next wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 16;
  localparam int A_CTRL   = 0;
  localparam int A_PERIOD = 1;
  localparam int A_POL    = 2;
  localparam int A_OEN    = 3;
  localparam int A_BUF0   = 4;
  localparam int A_DUTY0  = 8;
  localparam int B_RUN    = 0;
  localparam int B_IE     = 1;
  localparam int B_FLAG   = 2;
  localparam int B_ROUTE  = 3;
  localparam int B_SEL    = 4;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DW = (1 << SEL_W) - 1;

  logic [DW-1:0] div_q, div_d;
  logic [DW:0]   wide;
  logic [DW-1:0] mask;

  always_comb begin
    wide = ({{DW{1'b0}}, 1'b1} << sel) - 1'b1;
    mask = wide[DW-1:0];
    tick = ((div_q & mask) == mask);
    div_d = clr ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank #(
  parameter int CNT_W = 10,
  parameter int N_BUF = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        route,
  input  logic [N_BUF-1:0][CNT_W-1:0] buf_val,
  output logic [2*N_BUF-1:0][CNT_W-1:0] duty
);
  localparam int N_OUT = 2 * N_BUF;

  logic [N_OUT-1:0][CNT_W-1:0] duty_d;

  for (genvar g = 0; g < N_OUT; g++) begin : g_slot
    localparam int SRC  = g % N_BUF;
    localparam bit HIGH = (g >= N_BUF);
    logic take;
    assign take = load && (route == HIGH);

    always_comb duty_d[g] = take ? buf_val[SRC] : duty[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) duty[g] <= '0;
      else        duty[g] <= duty_d[g];
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 10,
  parameter int N_OUT = 8
) (
  input  logic                        active,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [CNT_W-1:0]            period,
  input  logic [N_OUT-1:0][CNT_W-1:0] duty,
  input  logic [N_OUT-1:0]            pol,
  input  logic [N_OUT-1:0]            oen,
  output logic [N_OUT-1:0]            pwm
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_ch
    logic raw;
    always_comb begin
      raw    = (cnt < duty[g]) || (duty[g] >= period);
      pwm[g] = (active && oen[g] && raw) ^ pol[g];
    end
  end
endmodule

// File: rtl/pwm_bank_timer.sv
module pwm_bank_timer
  import pwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int N_BUF = 4,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [7:0]        pwm_o,
  output logic              irq_o
);
  localparam int N_OUT = 2 * N_BUF;

  logic rst_sync_n;
  logic run_q, run_d, ie_q, ie_d, route_q, route_d, flag_q, flag_d, started_q;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] period_q, period_d, cnt_q, cnt_d;
  logic [N_OUT-1:0] pol_q, pol_d, oen_q, oen_d;
  logic [N_BUF-1:0][CNT_W-1:0] buf_q, buf_d;
  logic [N_OUT-1:0][CNT_W-1:0] duty;
  logic [N_OUT-1:0] pwm_int;
  logic tick, start, match, wr_ctrl;

  pwm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pwm_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .clr(!run_q || start), .sel(sel_q), .tick(tick)
  );

  pwm_duty_bank #(.CNT_W(CNT_W), .N_BUF(N_BUF)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .load(match), .route(route_q),
    .buf_val(buf_q), .duty(duty)
  );

  pwm_out_stage #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u_out (
    .active(run_q && started_q), .cnt(cnt_q), .period(period_q), .duty(duty),
    .pol(pol_q), .oen(oen_q), .pwm(pwm_int)
  );

  assign pwm_o = pwm_int[7:0];
  assign irq_o = flag_q && ie_q;

  // Next-state logic
  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    start    = run_q && !started_q;
    match    = start || (run_q && tick && (cnt_q == period_q));
    run_d    = run_q;
    ie_d     = ie_q;
    route_d  = route_q;
    sel_d    = sel_q;
    period_d = period_q;
    pol_d    = pol_q;
    oen_d    = oen_q;
    buf_d    = buf_q;
    if (wr_ctrl) begin
      run_d   = reg_wdata[B_RUN];
      ie_d    = reg_wdata[B_IE];
      route_d = reg_wdata[B_ROUTE];
      sel_d   = reg_wdata[B_SEL +: SEL_W];
    end
    if (reg_wr && reg_addr == ADDR_W'(A_PERIOD)) period_d = reg_wdata[CNT_W-1:0];
    if (reg_wr && reg_addr == ADDR_W'(A_POL))    pol_d    = reg_wdata[N_OUT-1:0];
    if (reg_wr && reg_addr == ADDR_W'(A_OEN))    oen_d    = reg_wdata[N_OUT-1:0];
    for (int i = 0; i < N_BUF; i++)
      if (reg_wr && reg_addr == ADDR_W'(A_BUF0 + i)) buf_d[i] = reg_wdata[CNT_W-1:0];
    if (match)                             flag_d = 1'b1;
    else if (wr_ctrl && !reg_wdata[B_FLAG]) flag_d = 1'b0;
    else                                   flag_d = flag_q;
    if (!run_q || match) cnt_d = '0;
    else if (tick)       cnt_d = cnt_q + 1'b1;
    else                 cnt_d = cnt_q;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q <= 1'b0; ie_q <= 1'b0; route_q <= 1'b0; flag_q <= 1'b0;
      started_q <= 1'b0; sel_q <= '0; period_q <= '0; cnt_q <= '0;
      pol_q <= '0; oen_q <= '0; buf_q <= '0;
    end else begin
      run_q <= run_d; ie_q <= ie_d; route_q <= route_d; flag_q <= flag_d;
      started_q <= run_q; sel_q <= sel_d; period_q <= period_d; cnt_q <= cnt_d;
      pol_q <= pol_d; oen_q <= oen_d; buf_q <= buf_d;
    end
  end

  // Read port
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      reg_rdata[B_RUN]   = run_q;
      reg_rdata[B_IE]    = ie_q;
      reg_rdata[B_FLAG]  = flag_q;
      reg_rdata[B_ROUTE] = route_q;
      reg_rdata[B_SEL +: SEL_W] = sel_q;
    end
    if (reg_addr == ADDR_W'(A_PERIOD)) reg_rdata[CNT_W-1:0] = period_q;
    if (reg_addr == ADDR_W'(A_POL))    reg_rdata[N_OUT-1:0] = pol_q;
    if (reg_addr == ADDR_W'(A_OEN))    reg_rdata[N_OUT-1:0] = oen_q;
    for (int i = 0; i < N_BUF; i++)
      if (reg_addr == ADDR_W'(A_BUF0 + i)) reg_rdata[CNT_W-1:0] = buf_q[i];
    for (int i = 0; i < N_OUT; i++)
      if (reg_addr == ADDR_W'(A_DUTY0 + i)) reg_rdata[CNT_W-1:0] = duty[i];
  end
endmodule

// File: rtl/pwm_bank_timer_chk.sv
module pwm_bank_timer_chk
  import pwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int N_OUT = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reg_wr,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic                        run_q,
  input logic                        flag_q,
  input logic                        match,
  input logic [CNT_W-1:0]            cnt_q,
  input logic [N_OUT-1:0][CNT_W-1:0] duty,
  input logic [N_OUT-1:0]            pol_q,
  input logic [N_OUT-1:0]            oen_q,
  input logic [7:0]                  pwm_o,
  input logic                        irq_o
);
  assert_wrap_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);

  assert_duty_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> $stable(duty));

  assert_disabled_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_o & ~oen_q[7:0]) == (pol_q[7:0] & ~oen_q[7:0])));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(reg_wr && reg_addr == ADDR_W'(A_CTRL))) |=> flag_q);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_q);

  assert_stop_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == '0));

  assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pwm_o == pol_q[7:0]));
endmodule

bind pwm_bank_timer pwm_bank_timer_chk #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .run_q(run_q), .flag_q(flag_q), .match(match), .cnt_q(cnt_q), .duty(duty),
  .pol_q(pol_q), .oen_q(oen_q), .pwm_o(pwm_o), .irq_o(irq_o)
);

// File: tb/tb_pwm_bank_timer.sv
`timescale 1ns/1ps
module tb_pwm_bank_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pwm_o;
  logic        irq_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_bank_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  // {period[47:38], code[37:35], duty[34:25], pol[24], ie[23], pad[22:12], high clocks[11:0]}
  localparam logic [47:0] VEC [0:6] = '{
    {10'd9, 3'd0, 10'd3,  1'b0, 1'b1, 11'd0, 12'd3},
    {10'd9, 3'd1, 10'd3,  1'b1, 1'b0, 11'd0, 12'd14},
    {10'd4, 3'd2, 10'd4,  1'b0, 1'b1, 11'd0, 12'd20},
    {10'd7, 3'd0, 10'd0,  1'b0, 1'b0, 11'd0, 12'd0},
    {10'd5, 3'd3, 10'd2,  1'b0, 1'b1, 11'd0, 12'd16},
    {10'd3, 3'd0, 10'd12, 1'b0, 1'b0, 11'd0, 12'd4},
    {10'd2, 3'd7, 10'd1,  1'b0, 1'b1, 11'd0, 12'd128}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    #12 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check("R11 pwm", pwm_o, 0);
    check("R11 irq", irq_o, 0);
    rd_reg(4'd0, rd); check("R11 ctrl", rd, 0);
    rd_reg(4'd8, rd); check("R11 duty0", rd, 0);

    // Table: waveform, period, flag and interrupt per vector
    for (int v = 0; v < 7; v++) begin
      logic [9:0]  per;
      logic [2:0]  code;
      logic [9:0]  dv;
      logic        pl, ie;
      logic [15:0] ctrl;
      int exp_hi, ptot, hi, en_bad;
      per = VEC[v][47:38]; code = VEC[v][37:35]; dv = VEC[v][34:25];
      pl = VEC[v][24]; ie = VEC[v][23]; exp_hi = int'(VEC[v][11:0]);
      ptot = (int'(per) + 1) << code;
      ctrl = {9'd0, code, 1'b0, 1'b0, ie, 1'b1};
      wr_reg(4'd0, 16'd0);
      wr_reg(4'd1, {6'd0, per});
      wr_reg(4'd4, {6'd0, dv});
      wr_reg(4'd2, {15'd0, pl});
      wr_reg(4'd3, 16'h0001);
      wr_reg(4'd0, ctrl);
      reg_addr = 4'd0;
      hi = 0; en_bad = 0;
      for (int i = 0; i < ptot; i++) begin
        @(negedge clk);
        if (i == 0) begin
          check("R1 flag on start", reg_rdata[2], 1);
          check("R9 irq follows enable", irq_o, ie);
          reg_wr = 1'b1; reg_wdata = ctrl;
        end
        if (i == 1) begin
          reg_wr = 1'b0;
          check("R8 flag cleared by 0 write", reg_rdata[2], 0);
          check("R9 irq low after clear", irq_o, 0);
        end
        if (pwm_o[0]) hi++;
        if (pwm_o[7:1] != 7'd0) en_bad++;
      end
      check("R5 R6 high clocks per period", hi, exp_hi);
      check("R7 disabled outputs idle", en_bad, 0);
      check("R2 no early wrap", reg_rdata[2], 0);
      @(negedge clk);
      check("R2 wrap after full period", reg_rdata[2], 1);
    end

    // R10: stop forces polarity level on every output
    wr_reg(4'd0, 16'd0);
    wr_reg(4'd2, 16'h00A5);
    wr_reg(4'd3, 16'h00FF);
    wr_reg(4'd1, 16'd9);
    wr_reg(4'd4, 16'd3);
    wr_reg(4'd0, 16'h0001);
    repeat (3) @(negedge clk);
    wr_reg(4'd0, 16'h0000);
    check("R10 stop idle level", pwm_o, 8'hA5);
    rd_reg(4'd8, rd); check("R10 duty kept after stop", rd, 3);

    // R8: writing 1 to the flag does not set it
    wr_reg(4'd0, 16'h0000);
    wr_reg(4'd0, 16'h0004);
    rd_reg(4'd0, rd); check("R8 write 1 ignored", rd[2], 0);

    // R3: buffer write mid-period waits for the wrap
    wr_reg(4'd2, 16'h0000);
    wr_reg(4'd0, 16'h0001);
    @(negedge clk);
    wr_reg(4'd4, 16'd7);
    rd_reg(4'd8, rd); check("R3 duty held before wrap", rd, 3);
    repeat (12) @(negedge clk);
    rd_reg(4'd8, rd); check("R3 duty updated at wrap", rd, 7);

    // R4: route bit sends buffers to the upper slots
    wr_reg(4'd0, 16'h0000);
    wr_reg(4'd5, 16'd6);
    wr_reg(4'd0, 16'h0009);
    @(negedge clk);
    rd_reg(4'd13, rd); check("R4 upper slot loaded", rd, 6);
    rd_reg(4'd9, rd);  check("R4 lower slot untouched", rd, 0);
    rd_reg(4'd8, rd);  check("R4 lower slot 0 untouched", rd, 7);
    wr_reg(4'd0, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule